// File: doc/BRIEF.md
# Trigger Pulse Shaper with Enforced Dead Time

The block converts a raw trigger request into a clean trigger pulse of programmable length and then stays deaf to new requests for a programmable holdoff interval. Both lengths are counted in clock ticks of the block clock. With a 4 ns tick the reset values give a 48 ns pulse and a 40 ns holdoff, 88 ns of dead time in total. Downstream logic that needs a minimum settling time per trigger can rely on the block never issuing triggers closer together than that time.

The hardware guarantees a floor on the dead time: when the programmed pulse width plus holdoff falls below the minimum (20 ticks by default), the holdoff is stretched so that the total equals the minimum. Requests that arrive as rising edges while the pulse or holdoff is running are discarded, and a saturating counter records how many were discarded. Parameters are loaded through a small write port. A new value is captured when the next trigger is accepted, so a write never alters a pulse or holdoff that is already running.

Top module: `trig_shaper`

## Requirements
- R1: While reset is asserted and after it is released, `trig_out` and `dead` are 0 and `reject_cnt` is 0. The reset values are pulse width 12 ticks and holdoff 10 ticks.
- R2: A low-to-high transition of `trig_req`, sampled on a clock edge while the block is idle, is accepted. `trig_out` is then high from the following cycle onwards.
- R3: `trig_out` stays high for exactly the programmed width in ticks. A programmed width of 0 behaves as 1.
- R4: `dead` is high from the first pulse cycle for width plus holdoff cycles in total. `trig_out` is never high while `dead` is low. A holdoff of 0 ends the dead time together with the pulse.
- R5: When width plus holdoff is below MIN_DEAD (20 ticks by default), `dead` lasts exactly MIN_DEAD cycles.
- R6: A rising edge of `trig_req` seen while `dead` is high produces no pulse and raises `reject_cnt` by one.
- R7: Holding `trig_req` high produces only one accepted trigger and no rejections until the input goes low and rises again.
- R8: `reject_cnt` saturates at its all-ones value and stays there.
- R9: A configuration write made during a pulse or holdoff does not change that pulse or holdoff. It applies from the next accepted trigger.
- R10: When `cfg_we` is high, `cfg_sel` = 0 writes `cfg_data` to the pulse width and `cfg_sel` = 1 writes it to the holdoff. The other parameter keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one tick of width and holdoff |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_req | input | 1 | Raw trigger request, acted on at its rising edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects pulse width, 1 selects holdoff |
| cfg_data | input | VAL_W (16) | Value to write, in ticks |
| trig_out | output | 1 | Shaped trigger pulse |
| dead | output | 1 | High during pulse and holdoff |
| reject_cnt | output | REJ_W (16) | Saturating count of dropped requests |

## Verification
The bench goes after the clamp: a width and holdoff whose sum is under the floor must still give exactly 20 dead cycles. A design that skips the clamp reopens early and the measured dead length comes out short. A zero width must give a one-cycle pulse; a design without this rule would give a 65536-tick pulse or none at all. A zero holdoff must end the dead time with the pulse, and an off-by-one in the holdoff reload shows up as a dead length one cycle too long or too short. Requests during dead time and a level held high check that only true edges in the idle state start a pulse. A rewrite in the middle of a pulse checks that the running pulse keeps its length. The saturating counter, built narrow in the bench, must stop at all-ones rather than wrap to a small value.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Phase of the trigger timing engine
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_HOLD  = 2'd2
  } trig_state_e;

  // Selector encoding on the configuration port
  localparam logic SEL_WIDTH = 1'b0;
  localparam logic SEL_HOLD  = 1'b1;

endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int VAL_W     = 16,
  parameter int DEF_WIDTH = 12,
  parameter int DEF_HOLD  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [VAL_W-1:0] cfg_data,
  output logic [VAL_W-1:0] width_val,
  output logic [VAL_W-1:0] hold_val
);

  localparam logic [VAL_W-1:0] RstWidth = VAL_W'(DEF_WIDTH);
  localparam logic [VAL_W-1:0] RstHold  = VAL_W'(DEF_HOLD);

  logic             width_en;
  logic             hold_en;
  logic [VAL_W-1:0] width_q;
  logic [VAL_W-1:0] hold_q;

  always_comb begin
    width_en = cfg_we && (cfg_sel == SEL_WIDTH);
    hold_en  = cfg_we && (cfg_sel == SEL_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= RstWidth;
    end else if (width_en) begin
      width_q <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= RstHold;
    end else if (hold_en) begin
      hold_q <= cfg_data;
    end
  end

  assign width_val = width_q;
  assign hold_val  = hold_q;

endmodule

// File: rtl/trig_timing_fsm.sv
module trig_timing_fsm
  import trig_pkg::*;
#(
  parameter int VAL_W    = 16,
  parameter int MIN_DEAD = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_req,
  input  logic [VAL_W-1:0] width_val,
  input  logic [VAL_W-1:0] hold_val,
  output logic             pulse_o,
  output logic             dead_o,
  output logic             reject_o
);

  localparam logic [VAL_W:0]   MinDeadSum = (VAL_W+1)'(MIN_DEAD);
  localparam logic [VAL_W-1:0] MinDeadVal = VAL_W'(MIN_DEAD);
  localparam logic [VAL_W-1:0] OneTick    = VAL_W'(1);

  trig_state_e      state_q, state_d;
  logic [VAL_W-1:0] cnt_q, cnt_d;
  logic [VAL_W-1:0] hold_len_q, hold_len_d;
  logic             req_q;
  logic             rise;
  logic             accept;

  logic [VAL_W-1:0] w_eff;
  logic [VAL_W:0]   dead_sum;
  logic [VAL_W-1:0] h_eff;

  // Effective lengths captured at acceptance
  always_comb begin
    w_eff    = (width_val == '0) ? OneTick : width_val;
    dead_sum = {1'b0, w_eff} + {1'b0, hold_val};
    if (dead_sum < MinDeadSum) begin
      h_eff = MinDeadVal - w_eff;
    end else begin
      h_eff = hold_val;
    end
  end

  always_comb begin
    rise   = trig_req && !req_q;
    accept = rise && (state_q == ST_IDLE);
  end

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    hold_len_d = hold_len_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d    = ST_PULSE;
          cnt_d      = w_eff - OneTick;
          hold_len_d = h_eff;
        end
      end
      ST_PULSE: begin
        if (cnt_q == '0) begin
          if (hold_len_q == '0) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_HOLD;
            cnt_d   = hold_len_q - OneTick;
          end
        end else begin
          cnt_d = cnt_q - OneTick;
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - OneTick;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= trig_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      hold_len_q <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      hold_len_q <= hold_len_d;
    end
  end

  assign pulse_o  = (state_q == ST_PULSE);
  assign dead_o   = (state_q != ST_IDLE);
  assign reject_o = rise && (state_q != ST_IDLE);

endmodule

// File: rtl/trig_reject_ctr.sv
module trig_reject_ctr #(
  parameter int REJ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reject_i,
  output logic [REJ_W-1:0] count_o
);

  logic [REJ_W-1:0] count_q;
  logic             full;
  logic             inc_en;

  always_comb begin
    full   = (count_q == '1);
    inc_en = reject_i && !full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (inc_en) begin
      count_q <= count_q + REJ_W'(1);
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/trig_shaper.sv
module trig_shaper
  import trig_pkg::*;
#(
  parameter int VAL_W     = 16,
  parameter int REJ_W     = 16,
  parameter int DEF_WIDTH = 12,
  parameter int DEF_HOLD  = 10,
  parameter int MIN_DEAD  = 20,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_req,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [VAL_W-1:0] cfg_data,
  output logic             trig_out,
  output logic             dead,
  output logic [REJ_W-1:0] reject_cnt
);

  logic             rst_n_int;
  logic [VAL_W-1:0] width_val;
  logic [VAL_W-1:0] hold_val;
  logic             reject;

  trig_rst_sync #(
    .STAGES (SYNC_STG)
  ) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  trig_cfg_regs #(
    .VAL_W     (VAL_W),
    .DEF_WIDTH (DEF_WIDTH),
    .DEF_HOLD  (DEF_HOLD)
  ) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .width_val (width_val),
    .hold_val  (hold_val)
  );

  trig_timing_fsm #(
    .VAL_W    (VAL_W),
    .MIN_DEAD (MIN_DEAD)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .trig_req  (trig_req),
    .width_val (width_val),
    .hold_val  (hold_val),
    .pulse_o   (trig_out),
    .dead_o    (dead),
    .reject_o  (reject)
  );

  trig_reject_ctr #(
    .REJ_W (REJ_W)
  ) i_rej (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .reject_i (reject),
    .count_o  (reject_cnt)
  );

endmodule

// File: rtl/trig_shaper_chk.sv
module trig_shaper_chk #(
  parameter int REJ_W    = 16,
  parameter int MIN_DEAD = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_out,
  input logic             dead,
  input logic [REJ_W-1:0] reject_cnt
);

  // Length of the current dead interval, counted independently of the FSM
  logic [17:0] dead_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dead_run_q <= '0;
    end else if (dead) begin
      if (dead_run_q != '1) begin
        dead_run_q <= dead_run_q + 18'd1;
      end
    end else begin
      dead_run_q <= '0;
    end
  end

  assert_pulse_in_dead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> dead);

  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> $past(!dead));

  assert_min_dead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dead) |-> (dead_run_q >= 18'(MIN_DEAD)));

  assert_rej_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reject_cnt == $past(reject_cnt)) ||
              (reject_cnt == $past(reject_cnt) + REJ_W'(1))));

  assert_rej_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reject_cnt == '1) |=> (reject_cnt == '1));

endmodule

bind trig_shaper trig_shaper_chk #(
  .REJ_W    (REJ_W),
  .MIN_DEAD (MIN_DEAD)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_out   (trig_out),
  .dead       (dead),
  .reject_cnt (reject_cnt)
);

// File: tb/test_trig_shaper.sv
`timescale 1ns/1ps
module test_trig_shaper;

  localparam int VAL_W = 16;
  localparam int REJ_W = 6;

  typedef struct {
    int start;
    int w;
    int d;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic             trig_req;
  logic             cfg_we;
  logic             cfg_sel;
  logic [VAL_W-1:0] cfg_data;
  logic             trig_out;
  logic             dead;
  logic [REJ_W-1:0] reject_cnt;

  int   tests = 0;
  int   fails = 0;
  int   cyc   = 0;
  int   cur_w = 12;
  int   cur_h = 10;
  bit   done  = 0;
  exp_t sb_q[$];

  trig_shaper #(
    .VAL_W (VAL_W),
    .REJ_W (REJ_W)
  ) i_trig_shaper (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_req   (trig_req),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_data   (cfg_data),
    .trig_out   (trig_out),
    .dead       (dead),
    .reject_cnt (reject_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_width(int w);
    return (w == 0) ? 1 : w;
  endfunction

  function automatic int exp_dead(int w, int h);
    int s;
    s = exp_width(w) + h;
    return (s < 20) ? 20 : s;
  endfunction

  // Driver: issue one edge and push what the scoreboard must see
  task automatic fire();
    exp_t e;
    @(negedge clk);
    trig_req = 1'b1;
    e.start  = cyc + 1;
    e.w      = exp_width(cur_w);
    e.d      = exp_dead(cur_w, cur_h);
    sb_q.push_back(e);
    @(negedge clk);
    trig_req = 1'b0;
  endtask

  // R10: sel 0 -> width, sel 1 -> holdoff
  task automatic cfg_write(bit sel, int val);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_sel  = sel;
    cfg_data = VAL_W'(val);
    if (sel) cur_h = val; else cur_w = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: measure each pulse and compare against the queue
  initial begin
    bit   prev_out  = 0;
    bit   prev_dead = 0;
    bit   active    = 0;
    int   pw = 0;
    int   dl = 0;
    exp_t cur;
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      if (rst_n) begin
        if (trig_out && !prev_out) begin
          if (sb_q.size() == 0) begin
            chk("R6", "unexpected pulse start", cyc, -1);
            active = 0;
          end else begin
            cur    = sb_q.pop_front();
            active = 1;
            pw     = 0;
            dl     = 0;
            chk("R2", "pulse start cycle", cyc, cur.start);
          end
        end
        if (active) begin
          if (trig_out) pw++;
          if (dead) dl++;
          if (prev_dead && !dead) begin
            chk("R3", "pulse width", pw, cur.w);
            chk("R4", "dead length", dl, cur.d);
            active = 0;
          end
        end
      end
      prev_out  = trig_out;
      prev_dead = dead;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk("WD", "watchdog expired", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    trig_req = 1'b0;
    cfg_we   = 1'b0;
    cfg_sel  = 1'b0;
    cfg_data = '0;
    idle(5);
    chk("R1", "trig_out in reset", int'(trig_out), 0);
    chk("R1", "dead in reset", int'(dead), 0);
    rst_n = 1'b1;
    idle(5);
    chk("R1", "reject_cnt after reset", int'(reject_cnt), 0);
    chk("R1", "dead after reset", int'(dead), 0);

    // R1/R3/R4: reset values 12 + 10 -> 22
    fire();
    idle(30);

    // R5: 3 + 2 clamped to 20
    cfg_write(1'b0, 3);
    cfg_write(1'b1, 2);
    fire();
    idle(30);

    // R3: width 0 behaves as 1; R10 holdoff write alone
    cfg_write(1'b0, 0);
    cfg_write(1'b1, 30);
    fire();
    idle(40);

    // R4: holdoff 0 ends dead with the pulse
    cfg_write(1'b0, 25);
    cfg_write(1'b1, 0);
    fire();
    idle(35);

    // R10: only holdoff changes, width stays 25
    cfg_write(1'b1, 7);
    fire();
    idle(40);

    // R6: three edges during dead time are dropped and counted
    cfg_write(1'b0, 10);
    cfg_write(1'b1, 10);
    fire();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); trig_req = 1'b1;
      @(negedge clk); trig_req = 1'b0;
    end
    idle(30);
    chk("R6", "reject_cnt after 3 drops", int'(reject_cnt), 3);

    // R7: level held high gives one pulse, no drops
    cfg_write(1'b0, 4);
    cfg_write(1'b1, 4);
    @(negedge clk);
    begin
      exp_t e;
      trig_req = 1'b1;
      e.start  = cyc + 1;
      e.w      = 4;
      e.d      = 20;
      sb_q.push_back(e);
    end
    idle(60);
    trig_req = 1'b0;
    idle(5);
    chk("R7", "reject_cnt with held level", int'(reject_cnt), 3);

    // R9: rewrite during a pulse leaves it alone
    cfg_write(1'b0, 8);
    cfg_write(1'b1, 12);
    fire();
    cfg_write(1'b0, 30);
    idle(30);
    fire();
    idle(50);

    // R8: saturation of the narrow counter at 63
    cfg_write(1'b0, 200);
    cfg_write(1'b1, 0);
    fire();
    for (int i = 0; i < 70; i++) begin
      @(negedge clk); trig_req = 1'b1;
      @(negedge clk); trig_req = 1'b0;
    end
    idle(100);
    chk("R8", "reject_cnt saturated", int'(reject_cnt), 63);

    idle(5);
    chk("R2", "all expected pulses seen", sb_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule